// File: doc/BRIEF.md
# Multi-Block Card Read DMA Sequencer

This block drives the data path of a memory-card read. Software loads a block count and a DMA control word, then issues a start strobe. The sequencer asks the command serializer to send the read command and waits for it to finish. It then waits for the response and, once the response is good, starts the data serializer. Every word the data serializer delivers goes into a receive FIFO. A request line tells the system DMA engine when words are ready to drain.

In auto mode, each block that ends without error starts the next block read on its own. A block counter counts down as blocks complete, and the run ends when the counter runs out. After the run, a dedicated transfer-set code lets the DMA engine drain any words left below the streaming threshold. Errors halt the sequence until software sends command-off. All event flags are sticky and are cleared by writing 1 to them.

Top module: `cardrd_dma_seq`

## Requirements
- R1: `dma_req` is never high while the DMA enable bit (control register at address 0, bit 0) is 0.
- R2: While streaming, `dma_req` is high exactly when the FIFO holds at least 4 words. Each cycle with `dma_req` and `dma_ack` both high removes one word.
- R3: When the sequencer is idle and the transfer-set field (control bits [4:2]) holds 3'b100, `dma_req` stays high while the FIFO is not empty. Any other code leaves words below the threshold unrequested.
- R4: The FIFO returns words in arrival order on `dma_rdata`, and its level appears in status bits [12:8]. A clear strobe (write 1 to bit 2 at address 1) makes the level 0 in the next cycle.
- R5: The busy flag (status bit 0) goes high the cycle after a start strobe (bit 0 at address 1, honoured only when idle, with `cmd_go` pulsing in that cycle). It stays high until the sequence ends.
- R6: The block count (address 2, loadable only when idle) drops by one at each error-free block end. When the auto bit (control bit 1) is 1 and blocks remain, `dat_go` pulses in the same cycle as the block end. When the count is 1 or 0 at a block end, the block-transfer-end flag (status bit 1) is set and busy clears.
- R7: With the auto bit at 0, a block end that leaves a nonzero count returns the block to idle without `dat_go` and without the block-transfer-end flag.
- R8: `rsp_timeout` during the response wait sets the command-timeout flag (status bit 2). The sequence then halts with busy high until command-off (bit 1 at address 1) is written.
- R9: `dat_crc_err` or `rsp_crc_err` sets the CRC flag (status bit 3), and `dat_timeout` sets the data-timeout flag (status bit 4). A data error aborts the run with no auto-resume and no further word capture, and the block count is left unchanged until command-off.
- R10: Flags in status bits [4:1] stay set until a status write with a 1 in that bit. `irq` is high while any of these flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 command, 2 block count, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmd_go | output | 1 | Pulse: send the read command |
| cmd_done | input | 1 | Command transmission finished |
| rsp_valid | input | 1 | Good response received |
| rsp_timeout | input | 1 | No response in time |
| rsp_crc_err | input | 1 | Response CRC mismatch |
| dat_go | output | 1 | Pulse: start reading a data block |
| dat_valid | input | 1 | Data word strobe |
| dat_word | input | 32 | Received data word |
| dat_blk_end | input | 1 | Current block finished |
| dat_crc_err | input | 1 | Data CRC mismatch |
| dat_timeout | input | 1 | Data did not arrive in time |
| dma_req | output | 1 | Request to the DMA engine |
| dma_ack | input | 1 | DMA engine takes the head word |
| dma_rdata | output | 32 | FIFO head word |
| irq | output | 1 | Any sticky flag set |

## Verification
A wrong sequencer state shows up at once on `cmd_go` or `dat_go`, because both are decoded in the same cycle as the handshake that causes them. It also shows on the busy bit one cycle later. A block counter that is off by one causes a missing or extra auto-resume pulse at the block end where the count crosses 1, and the count register then reads back wrong in the next cycle. FIFO pointer or level faults appear as an out-of-order `dma_rdata`, or as `dma_req` flipping one word early or late around the threshold and during the final drain.

// File: rtl/cardrd_pkg.sv
package cardrd_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CMD,
      SQ_RSP,
      SQ_DAT,
      SQ_HALT
   } sq_state_e;

   typedef struct packed {
      logic dto;
      logic crc;
      logic cto;
      logic bte;
   } evt_t;

   localparam logic [2:0] XSET_FLUSH = 3'b100;
   localparam logic [1:0] RA_CTRL = 2'd0;
   localparam logic [1:0] RA_CMD  = 2'd1;
   localparam logic [1:0] RA_BCNT = 2'd2;
   localparam logic [1:0] RA_STAT = 2'd3;
endpackage

// File: rtl/cardrd_rxfifo.sv
module cardrd_rxfifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [LW-1:0] level
);
   localparam int PW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("cardrd_rxfifo: DEPTH must be a power of two, at least 4");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          full, empty, do_wr, do_rd;

   assign full    = (level == LW'(DEPTH));
   assign empty   = (level == '0);
   assign do_wr   = wr_en && !full && !clr;
   assign do_rd   = rd_en && !empty && !clr;
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_wr) wp <= wp + 1'b1;
         if (do_rd) rp <= rp + 1'b1;
         level <= level + LW'(do_wr) - LW'(do_rd);
      end
   end

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (level == '0)); // R4
   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LW'(DEPTH)); // R4
endmodule

// File: rtl/cardrd_dreq.sv
module cardrd_dreq import cardrd_pkg::*; #(
   parameter int LW       = 5,
   parameter int THRESH   = 4,
   parameter bit FLUSH_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dma_en,
   input  logic [2:0]    xfer_set,
   input  logic          seq_idle,
   input  logic [LW-1:0] level,
   output logic          dma_req
);
   logic stream_req, flush_req;

   initial begin
      assert (THRESH >= 1 && THRESH < (1 << LW))
         else $error("cardrd_dreq: THRESH out of range for level width");
   end

   assign stream_req = (level >= LW'(THRESH));

   generate
      if (FLUSH_EN) begin : g_flush
         assign flush_req = seq_idle && (xfer_set == XSET_FLUSH) && (level != '0);
      end else begin : g_noflush
         assign flush_req = 1'b0;
      end
   endgenerate

   assign dma_req = dma_en && (stream_req || flush_req);

   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> dma_en); // R1
   AST_LOW_LEVEL_ONLY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && level < LW'(THRESH)) |-> (seq_idle && xfer_set == XSET_FLUSH)); // R3
endmodule

// File: rtl/cardrd_seq.sv
module cardrd_seq import cardrd_pkg::*; #(
   parameter int BCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           cmd_off,
   input  logic           bcnt_we,
   input  logic [BCW-1:0] bcnt_wdata,
   input  logic           auto_en,
   input  logic           cmd_done,
   input  logic           rsp_valid,
   input  logic           rsp_timeout,
   input  logic           rsp_crc_err,
   input  logic           dat_blk_end,
   input  logic           dat_crc_err,
   input  logic           dat_timeout,
   output sq_state_e      state,
   output logic [BCW-1:0] bcnt,
   output evt_t           evt,
   output logic           cmd_go,
   output logic           dat_go,
   output logic           dat_accept
);
   sq_state_e      nxt;
   logic [BCW-1:0] bcnt_nxt;
   logic           last_blk, dat_err;

   assign dat_err    = dat_crc_err || dat_timeout;
   assign last_blk   = (bcnt <= BCW'(1));
   assign dat_accept = (state == SQ_DAT) && !dat_err && !cmd_off;

   always_comb begin
      nxt      = state;
      bcnt_nxt = bcnt;
      evt      = '0;
      cmd_go   = 1'b0;
      dat_go   = 1'b0;
      unique case (state)
         SQ_IDLE: begin
            if (start) begin
               nxt    = SQ_CMD;
               cmd_go = 1'b1;
            end else if (bcnt_we) begin
               bcnt_nxt = bcnt_wdata;
            end
         end
         SQ_CMD: if (cmd_done) nxt = SQ_RSP;
         SQ_RSP: begin
            if (rsp_timeout) begin
               nxt     = SQ_HALT;
               evt.cto = 1'b1;
            end else if (rsp_crc_err) begin
               nxt     = SQ_HALT;
               evt.crc = 1'b1;
            end else if (rsp_valid) begin
               nxt    = SQ_DAT;
               dat_go = 1'b1;
            end
         end
         SQ_DAT: begin
            if (dat_crc_err) begin
               nxt     = SQ_HALT;
               evt.crc = 1'b1;
            end else if (dat_timeout) begin
               nxt     = SQ_HALT;
               evt.dto = 1'b1;
            end else if (dat_blk_end) begin
               bcnt_nxt = (bcnt == '0) ? '0 : bcnt - 1'b1;
               if (last_blk) begin
                  nxt     = SQ_IDLE;
                  evt.bte = 1'b1;
               end else if (auto_en) begin
                  dat_go = 1'b1;
               end else begin
                  nxt = SQ_IDLE;
               end
            end
         end
         SQ_HALT: nxt = SQ_HALT;
         default: nxt = SQ_IDLE;
      endcase
      if (cmd_off) begin
         nxt    = SQ_IDLE;
         cmd_go = 1'b0;
         dat_go = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         bcnt  <= '0;
      end else begin
         state <= nxt;
         bcnt  <= bcnt_nxt;
      end
   end

   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_HALT && !cmd_off) |=> (state == SQ_HALT)); // R8
   AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_DAT && dat_blk_end && !dat_err && !cmd_off && bcnt != '0)
      |=> (bcnt == $past(bcnt) - 1'b1)); // R6
   AST_MANUAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_DAT && dat_blk_end && !dat_err && !cmd_off && !auto_en)
      |=> (state == SQ_IDLE)); // R7
   AST_ERR_NO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_DAT && dat_err) |-> !dat_go); // R9
endmodule

// File: rtl/cardrd_dma_seq.sv
module cardrd_dma_seq import cardrd_pkg::*; #(
   parameter int DW       = 32,
   parameter int DEPTH    = 16,
   parameter int THRESH   = 4,
   parameter int BCW      = 16,
   parameter bit FLUSH_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          cmd_go,
   input  logic          cmd_done,
   input  logic          rsp_valid,
   input  logic          rsp_timeout,
   input  logic          rsp_crc_err,
   output logic          dat_go,
   input  logic          dat_valid,
   input  logic [DW-1:0] dat_word,
   input  logic          dat_blk_end,
   input  logic          dat_crc_err,
   input  logic          dat_timeout,
   output logic          dma_req,
   input  logic          dma_ack,
   output logic [DW-1:0] dma_rdata,
   output logic          irq
);
   localparam int LW      = $clog2(DEPTH + 1);
   localparam int LVL_LSB = 8;

   initial begin
      assert (BCW <= 32 && LVL_LSB + LW <= 32 && DW >= 1)
         else $error("cardrd_dma_seq: parameter widths exceed register width");
   end

   logic           dma_en, auto_en;
   logic [2:0]     xfer_set;
   logic           wr_ctrl, wr_cmd, wr_bcnt, wr_stat;
   logic           start, cmd_off, fifo_clr, dat_accept;
   sq_state_e      state;
   logic [BCW-1:0] bcnt;
   evt_t           evt, flags, w1c;
   logic [LW-1:0]  level;
   logic           unused_wbits;

   assign wr_ctrl  = reg_we && reg_addr == RA_CTRL;
   assign wr_cmd   = reg_we && reg_addr == RA_CMD;
   assign wr_bcnt  = reg_we && reg_addr == RA_BCNT;
   assign wr_stat  = reg_we && reg_addr == RA_STAT;
   assign start    = wr_cmd && reg_wdata[0];
   assign cmd_off  = wr_cmd && reg_wdata[1];
   assign fifo_clr = wr_cmd && reg_wdata[2];
   assign w1c      = wr_stat ? evt_t'(reg_wdata[4:1]) : '0;
   assign unused_wbits = ^reg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dma_en   <= 1'b0;
         auto_en  <= 1'b0;
         xfer_set <= '0;
         flags    <= '0;
      end else begin
         if (wr_ctrl) begin
            dma_en   <= reg_wdata[0];
            auto_en  <= reg_wdata[1];
            xfer_set <= reg_wdata[4:2];
         end
         flags <= (flags & ~w1c) | evt;
      end
   end

   cardrd_seq #(.BCW(BCW)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .cmd_off     (cmd_off),
      .bcnt_we     (wr_bcnt),
      .bcnt_wdata  (reg_wdata[BCW-1:0]),
      .auto_en     (auto_en),
      .cmd_done    (cmd_done),
      .rsp_valid   (rsp_valid),
      .rsp_timeout (rsp_timeout),
      .rsp_crc_err (rsp_crc_err),
      .dat_blk_end (dat_blk_end),
      .dat_crc_err (dat_crc_err),
      .dat_timeout (dat_timeout),
      .state       (state),
      .bcnt        (bcnt),
      .evt         (evt),
      .cmd_go      (cmd_go),
      .dat_go      (dat_go),
      .dat_accept  (dat_accept)
   );

   cardrd_rxfifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fifo_clr),
      .wr_en   (dat_valid && dat_accept),
      .wr_data (dat_word),
      .rd_en   (dma_req && dma_ack),
      .rd_data (dma_rdata),
      .level   (level)
   );

   cardrd_dreq #(.LW(LW), .THRESH(THRESH), .FLUSH_EN(FLUSH_EN)) u_dreq (
      .clk      (clk),
      .rst_n    (rst_n),
      .dma_en   (dma_en),
      .xfer_set (xfer_set),
      .seq_idle (state == SQ_IDLE),
      .level    (level),
      .dma_req  (dma_req)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: reg_rdata[4:0] = {xfer_set, auto_en, dma_en};
         RA_CMD:  reg_rdata = '0;
         RA_BCNT: reg_rdata[BCW-1:0] = bcnt;
         RA_STAT: begin
            reg_rdata[0]                = (state != SQ_IDLE);
            reg_rdata[4:1]              = flags;
            reg_rdata[LVL_LSB +: LW]    = level;
         end
         default: reg_rdata = '0;
      endcase
   end

   assign irq = |flags;

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ((flags & $past(flags)) == $past(flags))); // R10
   AST_NO_CAPTURE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_HALT && !fifo_clr) |=> (level <= $past(level))); // R9
endmodule

// File: tb/cardrd_dma_seq_tb.sv
module cardrd_dma_seq_tb;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmd_go, dat_go, dma_req, irq;
   logic        cmd_done = 0, rsp_valid = 0, rsp_timeout = 0, rsp_crc_err = 0;
   logic        dat_valid = 0, dat_blk_end = 0, dat_crc_err = 0, dat_timeout = 0;
   logic        dma_ack = 0;
   logic [31:0] dat_word = '0;
   logic [31:0] dma_rdata;

   int total = 0;
   int errs  = 0;
   logic finished = 1'b0;

   always #(CLK_NS / 2) clk = ~clk;

   cardrd_dma_seq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_go(cmd_go),
      .cmd_done(cmd_done), .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
      .rsp_crc_err(rsp_crc_err), .dat_go(dat_go), .dat_valid(dat_valid),
      .dat_word(dat_word), .dat_blk_end(dat_blk_end), .dat_crc_err(dat_crc_err),
      .dat_timeout(dat_timeout), .dma_req(dma_req), .dma_ack(dma_ack),
      .dma_rdata(dma_rdata), .irq(irq)
   );

   typedef struct packed {
      logic [15:0] cnt;
      logic        au;
      logic [7:0]  blocks;
      logic        bte;
      logic [15:0] remain;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{cnt: 16'd3, au: 1'b1, blocks: 8'd3, bte: 1'b1, remain: 16'd0},
      '{cnt: 16'd3, au: 1'b0, blocks: 8'd1, bte: 1'b0, remain: 16'd2},
      '{cnt: 16'd1, au: 1'b1, blocks: 8'd1, bte: 1'b1, remain: 16'd0},
      '{cnt: 16'd0, au: 1'b1, blocks: 8'd1, bte: 1'b1, remain: 16'd0},
      '{cnt: 16'd5, au: 1'b1, blocks: 8'd5, bte: 1'b1, remain: 16'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1;
      tick();
      s = 1'b0;
   endtask

   task automatic get_status(output logic busy, output logic [3:0] fl, output int lvl);
      logic [31:0] v;
      reg_rd(2'd3, v);
      busy = v[0]; fl = v[4:1]; lvl = int'(v[12:8]);
   endtask

   // start a read and bring it to the data phase; returns 1 if dat_go pulsed
   task automatic to_data(output logic go);
      reg_wr(2'd1, 32'h1);
      pulse(cmd_done);
      rsp_valid = 1'b1;
      #1 go = dat_go;
      tick();
      rsp_valid = 1'b0;
   endtask

   task automatic run_read(input logic [15:0] cnt, input logic au, output int nblk);
      logic go, resume;
      nblk = 0;
      reg_wr(2'd1, 32'h4);
      reg_wr(2'd2, {16'd0, cnt});
      reg_wr(2'd0, {30'd0, au, 1'b0});
      to_data(go);
      if (go) nblk++;
      for (int b = 0; b < 10; b++) begin
         dat_word = 32'h100 + b;
         pulse(dat_valid);
         dat_blk_end = 1'b1;
         #1 resume = dat_go;
         tick();
         dat_blk_end = 1'b0;
         if (resume) nblk++;
         else break;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errs++; total++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, total);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic        busy, go;
      logic [3:0]  fl;
      int          lvl, nblk;

      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // reset state
      get_status(busy, fl, lvl);
      chk("R5 reset busy", busy, 0);
      chk("R10 reset flags", fl, 0);
      chk("R4 reset level", lvl, 0);
      reg_rd(2'd0, v);
      chk("R1 reset ctrl", v, 0);
      chk("R1 reset dma_req", dma_req, 0);
      chk("R10 reset irq", irq, 0);

      // table of block-count scenarios, DMA disabled throughout
      foreach (VEC[i]) begin
         reg_wr(2'd3, 32'h1E);
         run_read(VEC[i].cnt, VEC[i].au, nblk);
         chk($sformatf("R6 R7 vec%0d blocks", i), nblk, VEC[i].blocks);
         get_status(busy, fl, lvl);
         chk($sformatf("R5 vec%0d busy after end", i), busy, 0);
         chk($sformatf("R6 R7 vec%0d bte", i), fl[0], VEC[i].bte);
         chk($sformatf("R4 vec%0d level", i), lvl, VEC[i].blocks);
         reg_rd(2'd2, v);
         chk($sformatf("R6 vec%0d remain", i), v[15:0], VEC[i].remain);
         chk($sformatf("R1 vec%0d no req while disabled", i), dma_req, 0);
      end

      // FIFO clear strobe empties it (last vector left 5 words)
      reg_wr(2'd1, 32'h4);
      get_status(busy, fl, lvl);
      chk("R4 clear strobe", lvl, 0);
      reg_wr(2'd3, 32'h1E);
      chk("R10 w1c clears irq", irq, 0);

      // threshold, ordering and flush
      reg_wr(2'd2, 32'd1);
      reg_wr(2'd0, 32'h1);
      to_data(go);
      get_status(busy, fl, lvl);
      chk("R5 busy during read", busy, 1);
      for (int w = 0; w < 5; w++) begin
         dat_word = 32'hA0 + w;
         pulse(dat_valid);
         chk($sformatf("R2 req after %0d words", w + 1), dma_req, (w >= 3));
      end
      chk("R4 head word", dma_rdata, 32'hA0);
      pulse(dma_ack);
      chk("R2 req at level 4", dma_req, 1);
      chk("R4 second word", dma_rdata, 32'hA1);
      pulse(dma_ack);
      chk("R2 req drops at level 3", dma_req, 0);
      pulse(dat_blk_end);
      get_status(busy, fl, lvl);
      chk("R6 single block bte", fl[0], 1);
      chk("R3 no req without flush code", dma_req, 0);
      reg_wr(2'd0, 32'h11);
      chk("R3 flush raises req", dma_req, 1);
      for (int w = 2; w < 5; w++) begin
         chk($sformatf("R4 flush word %0d", w), dma_rdata, 32'hA0 + w);
         pulse(dma_ack);
      end
      chk("R3 flush ends at empty", dma_req, 0);
      get_status(busy, fl, lvl);
      chk("R3 level after flush", lvl, 0);

      // command timeout
      reg_wr(2'd0, 32'h0);
      reg_wr(2'd3, 32'h1E);
      reg_wr(2'd1, 32'h1);
      pulse(cmd_done);
      pulse(rsp_timeout);
      repeat (3) tick();
      get_status(busy, fl, lvl);
      chk("R8 timeout flag", fl[1], 1);
      chk("R8 busy held in halt", busy, 1);
      reg_wr(2'd1, 32'h2);
      get_status(busy, fl, lvl);
      chk("R8 cmd_off idles", busy, 0);
      chk("R10 flag sticky after cmd_off", fl[1], 1);
      chk("R10 irq while flag", irq, 1);
      reg_wr(2'd3, 32'h4);
      get_status(busy, fl, lvl);
      chk("R10 w1c timeout", fl, 0);

      // data CRC error in auto mode
      reg_wr(2'd1, 32'h4);
      reg_wr(2'd2, 32'd3);
      reg_wr(2'd0, 32'h2);
      to_data(go);
      chk("R6 dat_go after response", go, 1);
      dat_word = 32'h55;
      pulse(dat_valid);
      dat_crc_err = 1'b1;
      #1 chk("R9 no resume on crc", dat_go, 0);
      tick();
      dat_crc_err = 1'b0;
      dat_word = 32'h66;
      pulse(dat_valid);
      get_status(busy, fl, lvl);
      chk("R9 crc flag", fl[2], 1);
      chk("R9 busy after abort", busy, 1);
      chk("R9 no capture after abort", lvl, 1);
      reg_rd(2'd2, v);
      chk("R9 count untouched", v[15:0], 3);
      reg_wr(2'd1, 32'h2);
      reg_wr(2'd3, 32'h1E);

      // data timeout
      to_data(go);
      pulse(dat_timeout);
      get_status(busy, fl, lvl);
      chk("R9 data timeout flag", fl, 4'b1000);
      reg_wr(2'd1, 32'h2);
      get_status(busy, fl, lvl);
      chk("R5 idle after cmd_off", busy, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
   end
endmodule